// File: doc/BRIEF.md
# Thread-Steered Timer Interrupt Unit

This block serves one processor core that runs sixteen hardware threads sharing a single count-to-limit timer. A selection register holds one bit per thread. When the shared timer expires, the interrupt goes to every thread whose bit is set, each on its own output line. Threads can therefore share one timer and still choose, one by one, whether the next expiry reaches them.

Software reaches all state through a small auxiliary register port: the thread selection register, the running count, the limit, and a control register. The control register has an enable bit and a run bit. Any write to the control register clears the pending expiry. The value written decides what happens next. Enable plus run acknowledges and re-arms the timer. Run alone acknowledges and leaves the timer disarmed, which is what a thread does when it removes the last selected thread.

Top module: `thread_timer_irq_steer`

## Requirements
- R1: After reset the selection register, count, limit and control all read 0, and every interrupt output is low.
- R2: The selection register is at address 0xFFFFF850. A write stores bits [15:0] of the write data, and a read returns those bits with bits [31:16] as zero.
- R3: The count register (address 0x21) rises by one each clock while the run bit (control bit 1; control is at address 0x22) is set. It holds its value while the run bit is clear.
- R4: The limit register is at address 0x23. When the timer is running and count equals limit at a clock edge, count returns to 0 on that edge. If the enable bit (control bit 0) is set, an expiry becomes pending on that edge. After writing count 0 and then control 3, the interrupts rise exactly limit+1 clocks after the control write.
- R5: Interrupt output t is high exactly when an expiry is pending, enable is set and selection bit t is set. All selected threads are raised together.
- R6: Any control write clears the pending expiry. Writing 3 re-arms the timer, so the next count-to-limit match interrupts again. Writing 2 leaves it disarmed, so later matches raise no interrupt.
- R7: Clearing selection bit t drops output t on the clock after the write while the expiry stays pending. Setting the bit again raises output t again.
- R8: A count write sets count to the written value, and it takes precedence over the increment in the same clock.
- R9: Writes to any other address change no register, and reads of any other address return 0.
- R10: When a control write lands on the same clock as an expiry, the write wins. The pending flag ends clear, and count still wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aux_we | input | 1 | Register write strobe |
| aux_addr | input | 32 | Register address for reads and writes |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data for aux_addr, combinational |
| thread_irq | output | 16 | One interrupt line per hardware thread |

## Verification
The hardest case to reach is a control write that lands on the exact clock where count matches limit (R10). It only shows up when the write is timed to that one clock. The bench halts the timer, writes count 0 and a known limit, and starts the timer. It then counts whole clock periods from that write so the acknowledge falls on the expiry edge. It then checks that no output rose, that count wrapped to 0, and that the next match still interrupts. A second hard case is holding an expiry pending while selection bits are removed and restored (R7). The bench reaches it by leaving the pending flag unacknowledged through several selection writes.

// File: rtl/tts_pkg.sv
package tts_pkg;
    // Control register bit positions; software depends on these.
    localparam int CTRL_EN_POS  = 0;
    localparam int CTRL_RUN_POS = 1;
    localparam int CTRL_BITS    = 2;
endpackage

// File: rtl/tts_mask_reg.sv
module tts_mask_reg #(
    parameter int NT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [NT-1:0] wdata,
    output logic [NT-1:0] mask_o
);
    typedef struct packed {
        logic [NT-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mask = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/tts_shared_timer.sv
module tts_shared_timer
    import tts_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_we,
    input  logic          lim_we,
    input  logic          ctl_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] lim_o,
    output logic          en_o,
    output logic          run_o,
    output logic          pend_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] lim;
        logic          en;
        logic          run;
        logic          pend;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       match;

    always_comb begin
        st_d  = st_q;
        match = st_q.run && (st_q.cnt == st_q.lim);
        if (st_q.run) begin
            st_d.cnt = match ? '0 : st_q.cnt + DW'(1);
        end
        if (match && st_q.en) begin
            st_d.pend = 1'b1;
        end
        // Software writes take precedence over the timer's own update.
        if (cnt_we) begin
            st_d.cnt = wdata;
        end
        if (lim_we) begin
            st_d.lim = wdata;
        end
        if (ctl_we) begin
            st_d.en   = wdata[CTRL_EN_POS];
            st_d.run  = wdata[CTRL_RUN_POS];
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign lim_o  = st_q.lim;
    assign en_o   = st_q.en;
    assign run_o  = st_q.run;
    assign pend_o = st_q.pend;
endmodule

// File: rtl/tts_irq_fanout.sv
module tts_irq_fanout #(
    parameter int NT = 16
) (
    input  logic          pend,
    input  logic          en,
    input  logic [NT-1:0] mask,
    output logic [NT-1:0] irq
);
    logic fire;
    assign fire = pend & en;

    for (genvar t = 0; t < NT; t++) begin : g_thread
        assign irq[t] = fire & mask[t];
    end
endmodule

// File: rtl/thread_timer_irq_steer.sv
module thread_timer_irq_steer
    import tts_pkg::*;
#(
    parameter int          NUM_THREADS = 16,
    parameter int          DATA_W      = 32,
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] MASK_ADDR   = 32'hFFFF_F850,
    parameter logic [31:0] CNT_ADDR    = 32'h0000_0021,
    parameter logic [31:0] CTL_ADDR    = 32'h0000_0022,
    parameter logic [31:0] LIM_ADDR    = 32'h0000_0023
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   aux_we,
    input  logic [ADDR_W-1:0]      aux_addr,
    input  logic [DATA_W-1:0]      aux_wdata,
    output logic [DATA_W-1:0]      aux_rdata,
    output logic [NUM_THREADS-1:0] thread_irq
);
    localparam int PAD_W  = DATA_W - NUM_THREADS;
    localparam int CPAD_W = DATA_W - CTRL_BITS;

    logic                   sel_mask, sel_cnt, sel_ctl, sel_lim;
    logic [NUM_THREADS-1:0] mask_q;
    logic [DATA_W-1:0]      cnt_q, lim_q;
    logic                   en_q, run_q, pend_q;
    logic [CTRL_BITS-1:0]   ctl_view;

    always_comb begin
        sel_mask = (aux_addr == ADDR_W'(MASK_ADDR));
        sel_cnt  = (aux_addr == ADDR_W'(CNT_ADDR));
        sel_ctl  = (aux_addr == ADDR_W'(CTL_ADDR));
        sel_lim  = (aux_addr == ADDR_W'(LIM_ADDR));
    end

    tts_mask_reg #(.NT(NUM_THREADS)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (aux_we & sel_mask),
        .wdata  (aux_wdata[NUM_THREADS-1:0]),
        .mask_o (mask_q)
    );

    tts_shared_timer #(.DW(DATA_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_we (aux_we & sel_cnt),
        .lim_we (aux_we & sel_lim),
        .ctl_we (aux_we & sel_ctl),
        .wdata  (aux_wdata),
        .cnt_o  (cnt_q),
        .lim_o  (lim_q),
        .en_o   (en_q),
        .run_o  (run_q),
        .pend_o (pend_q)
    );

    tts_irq_fanout #(.NT(NUM_THREADS)) u_fan (
        .pend (pend_q),
        .en   (en_q),
        .mask (mask_q),
        .irq  (thread_irq)
    );

    always_comb begin
        ctl_view               = '0;
        ctl_view[CTRL_EN_POS]  = en_q;
        ctl_view[CTRL_RUN_POS] = run_q;
        if (sel_mask) begin
            aux_rdata = {{PAD_W{1'b0}}, mask_q};
        end else if (sel_cnt) begin
            aux_rdata = cnt_q;
        end else if (sel_ctl) begin
            aux_rdata = {{CPAD_W{1'b0}}, ctl_view};
        end else if (sel_lim) begin
            aux_rdata = lim_q;
        end else begin
            aux_rdata = '0;
        end
    end
endmodule

// File: rtl/tts_checker.sv
module tts_checker
    import tts_pkg::*;
#(
    parameter int          NT        = 16,
    parameter int          DW        = 32,
    parameter int          AW        = 32,
    parameter logic [31:0] MASK_ADDR = 32'hFFFF_F850,
    parameter logic [31:0] CNT_ADDR  = 32'h0000_0021,
    parameter logic [31:0] CTL_ADDR  = 32'h0000_0022,
    parameter logic [31:0] LIM_ADDR  = 32'h0000_0023
) (
    input logic          clk,
    input logic          rst_n,
    input logic          aux_we,
    input logic [AW-1:0] aux_addr,
    input logic [DW-1:0] aux_wdata,
    input logic [NT-1:0] irq,
    input logic [NT-1:0] mask,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] lim,
    input logic          run
);
    logic wr_cnt, wr_ctl, wr_mask, wr_other;
    assign wr_cnt   = aux_we && (aux_addr == AW'(CNT_ADDR));
    assign wr_ctl   = aux_we && (aux_addr == AW'(CTL_ADDR));
    assign wr_mask  = aux_we && (aux_addr == AW'(MASK_ADDR));
    assign wr_other = aux_we && (aux_addr != AW'(CNT_ADDR)) && (aux_addr != AW'(CTL_ADDR))
                      && (aux_addr != AW'(MASK_ADDR)) && (aux_addr != AW'(LIM_ADDR));

    assert_irq_in_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~mask) == '0);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> irq == '0);

    assert_mask_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (irq & ~$past(aux_wdata[NT-1:0])) == '0);

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_cnt && cnt != lim) |=> cnt == $past(cnt) + DW'(1));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_cnt && cnt == lim) |=> cnt == '0);

    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_other |=> ($stable(mask) && $stable(lim)));
endmodule

bind thread_timer_irq_steer tts_checker #(
    .NT(NUM_THREADS), .DW(DATA_W), .AW(ADDR_W), .MASK_ADDR(MASK_ADDR),
    .CNT_ADDR(CNT_ADDR), .CTL_ADDR(CTL_ADDR), .LIM_ADDR(LIM_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .aux_we    (aux_we),
    .aux_addr  (aux_addr),
    .aux_wdata (aux_wdata),
    .irq       (thread_irq),
    .mask      (mask_q),
    .cnt       (cnt_q),
    .lim       (lim_q),
    .run       (run_q)
);

// File: tb/thread_timer_irq_steer_tb.sv
module thread_timer_irq_steer_tb;
    localparam logic [31:0] A_MASK = 32'hFFFF_F850;
    localparam logic [31:0] A_CNT  = 32'h21;
    localparam logic [31:0] A_CTL  = 32'h22;
    localparam logic [31:0] A_LIM  = 32'h23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aux_we = 1'b0;
    logic [31:0] aux_addr = '0;
    logic [31:0] aux_wdata = '0;
    logic [31:0] aux_rdata;
    logic [15:0] thread_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    thread_timer_irq_steer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .aux_we     (aux_we),
        .aux_addr   (aux_addr),
        .aux_wdata  (aux_wdata),
        .aux_rdata  (aux_rdata),
        .thread_irq (thread_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; spans exactly one rising edge.
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        aux_addr  = a;
        aux_wdata = d;
        aux_we    = 1'b1;
        @(negedge clk);
        aux_we    = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        aux_addr = a;
        #1;
        d = aux_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_MASK, v); check("R1 mask", v, 0);
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_LIM, v);  check("R1 limit", v, 0);
        rd(A_CTL, v);  check("R1 control", v, 0);
        check("R1 irq", {16'h0, thread_irq}, 0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_A5C3);
        rd(A_MASK, v); check("R2 mask readback", v, 32'h0000_A5C3);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(A_LIM, 1000);
        wr(A_CNT, 0);
        wr(A_CTL, 2);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); check("R3 count runs", v, 5);
        wr(A_CTL, 0);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); check("R3 count holds", v, 6);
        check("R3 irq idle", {16'h0, thread_irq}, 0);
    endtask

    task automatic t_cnt_write();
        logic [31:0] v;
        wr(A_CTL, 2);
        wr(A_CNT, 100);
        rd(A_CNT, v); check("R8 count write wins", v, 100);
        wr(A_CTL, 0);
        rd(A_CNT, v); check("R8 count after write", v, 101);
    endtask

    task automatic t_expiry();
        logic [31:0] v;
        wr(A_MASK, 32'h8421);
        wr(A_LIM, 10);
        wr(A_CNT, 0);
        wr(A_CTL, 3);
        repeat (10) @(negedge clk);
        check("R4 no irq before match", {16'h0, thread_irq}, 0);
        @(negedge clk);
        check("R4 R5 irq at limit+1", {16'h0, thread_irq}, 32'h8421);
        rd(A_CNT, v); check("R4 count wrapped", v, 0);
        wr(A_MASK, 32'hFFFF);
        check("R5 all threads", {16'h0, thread_irq}, 32'hFFFF);
    endtask

    task automatic t_mask_drop();
        wr(A_MASK, 32'hFFF7);
        check("R7 bit3 dropped", {16'h0, thread_irq}, 32'hFFF7);
        wr(A_MASK, 32'hFFFF);
        check("R7 bit3 restored", {16'h0, thread_irq}, 32'hFFFF);
    endtask

    task automatic t_rearm();
        wr(A_CTL, 3);
        check("R6 ack clears", {16'h0, thread_irq}, 0);
        wr(A_CNT, 0);
        repeat (10) @(negedge clk);
        check("R6 rearm quiet", {16'h0, thread_irq}, 0);
        @(negedge clk);
        check("R6 rearm fires", {16'h0, thread_irq}, 32'hFFFF);
    endtask

    task automatic t_disarm();
        logic seen = 1'b0;
        wr(A_CTL, 2);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (thread_irq != 0) seen = 1'b1;
        end
        check("R6 disarmed stays low", {31'h0, seen}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(A_MASK, 32'h00F0);
        wr(32'h24, 32'hFFFF_FFFF);
        wr(32'hFFFF_F851, 32'hFFFF_FFFF);
        rd(A_MASK, v); check("R9 mask untouched", v, 32'h00F0);
        rd(A_LIM, v);  check("R9 limit untouched", v, 10);
        rd(32'h24, v); check("R9 unmapped reads 0", v, 0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr(A_CTL, 0);
        wr(A_LIM, 5);
        wr(A_CNT, 0);
        wr(A_CTL, 3);
        repeat (5) @(negedge clk);
        wr(A_CTL, 3);
        check("R10 ack beats expiry", {16'h0, thread_irq}, 0);
        rd(A_CNT, v); check("R10 count wrapped", v, 0);
        repeat (5) @(negedge clk);
        check("R10 quiet before next", {16'h0, thread_irq}, 0);
        @(negedge clk);
        check("R10 next expiry fires", {16'h0, thread_irq}, 32'h00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_count();
        t_cnt_write();
        t_expiry();
        t_mask_drop();
        t_rearm();
        t_disarm();
        t_unmapped();
        t_collision();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule